// File: doc/BRIEF.md
# Multiplier-Bit Window Selector

This block sits beside a bit-serial Montgomery multiplier core. It holds the multiplier operand X and gives the core one pair of multiplier bits {x(i+1), x(i)} in every cycle. The core looks at the pair, decides whether it can retire two iterations in this cycle (skip) or only one, and returns that decision. The core may also ask for the next cycle's low bit to be cancelled, when it has already added that bit's multiple one cycle early. The block then moves the window forward by one or two bit positions.

The operand register has no 1-bit shift path. Each register bit can only load, hold or take the bit two places above it. A one-bit displacement state records whether the current pair sits at register bits [1:0] or [2:1]. Single-bit advances are made by moving the window inside the low three bits, not by moving the data. When a load pulse arrives, it overrides the core's feedback in that cycle and restarts the walk at bit 0. Positions above the operand width read as zero, because zeros fill the register from the top.

Top module: `mwin_selector`

## Requirements
- R1: In the cycle after `load_i` is high, `pair_o` equals {X[1], X[0]} of the value loaded, and the walk index restarts at 0.
- R2: In a cycle without load in which `skip_i` is low, the pair in the next cycle starts one bit higher: index i becomes i+1.
- R3: In a cycle without load in which `skip_i` is high, the pair in the next cycle starts two bits higher: index i becomes i+2.
- R4: The operand register only loads, holds or shifts right by exactly two bits with zero fill at the top. It shifts in a non-load cycle when skip is high or the displacement state is 1, and holds otherwise.
- R5: The displacement state picks register bits [1:0] when 0 and bits [2:1] when 1. A non-skip cycle toggles it and a skip cycle leaves it unchanged. It is 0 after reset and after a load.
- R6: If `clr_lo_i` is high in a non-load cycle, bit 0 of `pair_o` in the next cycle is forced to 0 and bit 1 is unaffected. The forcing lasts only that one cycle.
- R7: `skip_i` and `clr_lo_i` have no effect in a cycle where `load_i` is high. In particular, the first pair after a load is never cleared.
- R8: After reset `pair_o` is 00.
- R9: Bit positions at or above the operand width `XW` appear as 0 in `pair_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load pulse; captures `load_x_i` and restarts the walk |
| load_x_i | input | XW | Multiplier operand X |
| skip_i | input | 1 | Core retires two iterations this cycle |
| clr_lo_i | input | 1 | Cancel the low bit of the next cycle's pair |
| pair_o | output | 2 | Current bit pair, {x(i+1), x(i)} |

## Verification
The hardest case to reach is a skip in a cycle where the displacement state is already 1. A double shift then has to leave the window displaced. This happens only after an odd number of single-bit advances followed by a skip. The stimulus reaches it with directed alternating skip patterns and long random skip runs from several loaded operands. All of these are compared against an index-based model that never considers register positions. Clear requests are mixed in at random, and one is placed on the load cycle, so that masking and its one-cycle lifetime are seen in both displacement states.

// File: rtl/mwin_pkg.sv
package mwin_pkg;

  // Choose the two-bit window out of the low three register bits and
  // apply the one-cycle cancellation of the low bit.
  function automatic logic [1:0] pick_pair(input logic [2:0] win,
                                           input logic       disp,
                                           input logic       clr);
    logic [1:0] raw;
    raw = disp ? win[2:1] : win[1:0];
    return {raw[1], raw[0] & ~clr};
  endfunction

  // The register must move two places once the window would leave
  // the low bits: on a skip, or when already displaced.
  function automatic logic shift_due(input logic skip, input logic disp);
    return skip | disp;
  endfunction

  // Window offset after the step: offset + 1 + skip, minus 2 when shifted.
  function automatic logic disp_next(input logic skip, input logic disp);
    return ~(skip ^ disp);
  endfunction

endpackage

// File: rtl/mwin_xreg.sv
module mwin_xreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  output logic [W-1:0] xr_q
);

  logic [W-1:0] xr_d;

  // Each bit: load, hold, or take the bit two places above (zero at top).
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic src;
    if (b + 2 < W) begin : g_mid
      assign src = xr_q[b+2];
    end else begin : g_top
      assign src = 1'b0;
    end
    assign xr_d[b] = load ? load_val[b] : (shift_en ? src : xr_q[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xr_q <= '0;
    else        xr_q <= xr_d;
  end

  // R1: a load lands as given
  p_load_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (xr_q == $past(load_val)));

  // R4: shift moves by exactly two with zero fill
  p_shift_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && shift_en) |=> (xr_q == ($past(xr_q) >> 2)));

  // R4: no shift means hold
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift_en) |=> $stable(xr_q));

endmodule

// File: rtl/mwin_disp.sv
module mwin_disp
  import mwin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic skip,
  input  logic clr_req,
  output logic shift_en,
  output logic disp_q,
  output logic clr_q
);

  assign shift_en = shift_due(skip, disp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= 1'b0;
      clr_q  <= 1'b0;
    end else if (load) begin
      disp_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      disp_q <= disp_next(skip, disp_q);
      clr_q  <= clr_req;
    end
  end

  // R5 / R7: a load restarts undisplaced and uncleared
  p_load_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!disp_q && !clr_q));

  // R5: single-bit advance from offset 0 moves the window up
  p_step_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !skip && !disp_q) |=> disp_q);

  // R5: single-bit advance from offset 1 uses the double shift and returns
  p_step_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !skip && disp_q) |=> !disp_q);

  // R5: a skip keeps the offset
  p_skip_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && skip) |=> (disp_q == $past(disp_q)));

endmodule

// File: rtl/mwin_pairsel.sv
module mwin_pairsel
  import mwin_pkg::*;
(
  input  logic [2:0] win,
  input  logic       disp,
  input  logic       clr,
  output logic [1:0] pair
);

  assign pair = pick_pair(win, disp, clr);

  always_comb begin
    // R6: the upper bit never sees the cancellation
    a_upper_free_r6: assert (pair[1] == (disp ? win[2] : win[1]));
  end

endmodule

// File: rtl/mwin_selector.sv
module mwin_selector #(
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [XW-1:0] load_x_i,
  input  logic          skip_i,
  input  logic          clr_lo_i,
  output logic [1:0]    pair_o
);

  localparam int WIN = 3;

  logic [XW-1:0]  xr_q;
  logic [WIN-1:0] win;
  logic           shift_en;
  logic           disp_q;
  logic           clr_q;

  mwin_disp u_disp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_i),
    .skip     (skip_i),
    .clr_req  (clr_lo_i),
    .shift_en (shift_en),
    .disp_q   (disp_q),
    .clr_q    (clr_q)
  );

  mwin_xreg #(.W(XW)) u_xreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_i),
    .load_val (load_x_i),
    .shift_en (shift_en),
    .xr_q     (xr_q)
  );

  assign win = xr_q[WIN-1:0];

  mwin_pairsel u_sel (
    .win  (win),
    .disp (disp_q),
    .clr  (clr_q),
    .pair (pair_o)
  );

  // R6: a clear request masks the next low bit
  p_clr_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && clr_lo_i) |=> (pair_o[0] == 1'b0));

  // R1 / R7: first pair after load is the operand's bottom two bits
  p_first_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (pair_o == $past(load_x_i[1:0])));

endmodule

// File: tb/mwin_selector_tb.sv
module mwin_selector_tb;

  localparam int XW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic [XW-1:0] load_x_i = '0;
  logic          skip_i = 1'b0;
  logic          clr_lo_i = 1'b0;
  logic [1:0]    pair_o;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  // Reference model: plain bit index into the loaded operand
  logic [XW-1:0] m_x = '0;
  int            m_idx = 0;
  logic          m_clr = 1'b0;

  always #4 clk = ~clk;

  mwin_selector #(.XW(XW)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .load_x_i (load_x_i),
    .skip_i   (skip_i),
    .clr_lo_i (clr_lo_i),
    .pair_o   (pair_o)
  );

  function automatic logic xbit(input logic [XW-1:0] v, input int k);
    return (k < XW) ? v[k] : 1'b0;
  endfunction

  function automatic logic [1:0] exp_pair();
    return {xbit(m_x, m_idx + 1), xbit(m_x, m_idx) & ~m_clr};
  endfunction

  task automatic check(input string req, input logic [1:0] got,
                       input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s idx=%0d pair=%b expected=%b", req, m_idx, got, exp);
    end
  endtask

  // Drive one cycle of inputs, advance the model at the edge, check after.
  task automatic step(input logic ld, input logic [XW-1:0] v,
                      input logic sk, input logic cl, input string req);
    load_i = ld; load_x_i = v; skip_i = sk; clr_lo_i = cl;
    @(posedge clk);
    if (ld) begin
      m_x = v; m_idx = 0; m_clr = 1'b0;
    end else begin
      m_idx = m_idx + 1 + int'(sk);
      m_clr = cl;
    end
    @(negedge clk);
    check(req, pair_o, exp_pair());
  endtask

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset", pair_o, 2'b00);

    // R1 and R7: load with clear and skip asserted; both must be ignored
    step(1'b1, 32'hB4E1_96C3, 1'b1, 1'b1, "R1 R7 load");
    // R2 single-bit advances
    for (int k = 0; k < 5; k++) step(1'b0, '0, 1'b0, 1'b0, "R2 step");
    // R3 double advances from displaced state
    for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b1, 1'b0, "R3 skip");
    // R5 alternation reaching skip while displaced
    for (int k = 0; k < 8; k++) step(1'b0, '0, 1'(k % 3 == 1), 1'b0, "R5 mix");
    // R6 clear for one cycle, then released
    step(1'b0, '0, 1'b0, 1'b1, "R6 clear");
    step(1'b0, '0, 1'b0, 1'b0, "R6 release");
    step(1'b0, '0, 1'b1, 1'b1, "R6 clear skip");
    step(1'b0, '0, 1'b1, 1'b0, "R6 release skip");

    // R7: reload mid-walk with skip high
    step(1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, "R7 reload");
    step(1'b0, '0, 1'b0, 1'b1, "R6 clear ones");
    step(1'b0, '0, 1'b0, 1'b0, "R2 ones");

    // R9: walk past the top of the operand
    step(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R1 load top");
    for (int k = 0; k < 15; k++) step(1'b0, '0, 1'b1, 1'b0, "R3 to top");
    step(1'b0, '0, 1'b0, 1'b0, "R9 top edge");
    for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b1, 1'b0, "R9 beyond");
    check("R9 zero fill", pair_o, 2'b00);

    // Constrained random walks, R2 R3 R4 R5 R6
    for (int run = 0; run < 6; run++) begin
      step(1'b1, $urandom, 1'($urandom % 2), 1'($urandom % 2), "R1 rand load");
      for (int k = 0; k < 30; k++)
        step(1'b0, '0, 1'($urandom % 2), 1'($urandom % 4 == 0), "R4 rand walk");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule